// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two bidirectional data buses, called A and B, through a pair of per-direction paths. Each path owns one storage register, one rising-edge capture clock, one output enable and one select input. The select picks, for the side being driven, either the live value on the opposite bus or the word held in that direction's register. The two enables have opposite polarities: the A-to-B enable is active high, while the B-to-A enable is active low. Captures happen on every rising capture-clock edge, whatever the enables and selects are doing.

Tri-state pins are modelled as separate input, output and output-enable vectors per bus. The value the block "sees" on a bus is the external input when the block is not driving that bus, and the block's own driven value when it is. That resolved value feeds both the opposite direction's live path and the register capture. When both directions are driven with both selects on live data, the two buses feed each other. The block then holds the A-bus value that was present just before that mode was entered, and ignores the inputs.

During reset, both output-enable vectors are zero and both registers are cleared.

Top module: `dualbus_xcvr`

## Requirements
- R1: While `rst_n` is 0, `a_oe` and `b_oe` are all zeros and both stored registers clear to 0. After release, a stored-select output reads 0 until a capture occurs.
- R2: `b_oe` is all ones exactly when `en_ab` is 1 (outside reset), and all zeros otherwise.
- R3: `a_oe` is all ones exactly when `en_ba_n` is 0 (outside reset), and all zeros when `en_ba_n` is 1.
- R4: A select at 0 passes live data. A driven B carries the resolved A-bus value, and a driven A carries the resolved B-bus value.
- R5: A select at 1 passes stored data. A driven B carries the A-side register, and a driven A carries the B-side register.
- R6: A rising edge of `clk_ab` loads the resolved A-bus value into the A-side register, whatever the enable and select inputs are. Input changes without an edge, and falling edges, leave it unchanged.
- R7: A rising edge of `clk_ba` loads the resolved B-bus value into the B-side register, whatever the enable and select inputs are.
- R8: With `en_ab`=0 and `en_ba_n`=1, neither bus is driven, and both registers still capture on their clocks.
- R9: With `en_ab`=1, `en_ba_n`=0 and both selects at 1, B carries the stored A word and A carries the stored B word at the same time.
- R10: With `en_ab`=1, `en_ba_n`=0 and both selects at 0, both buses carry the A-bus value held from just before the mode was entered. Changes on `a_in` and `b_in` have no effect in this mode.
- R11: A capture from a bus that the block is driving stores the driven value. For example, with only A driven from live B, pulsing both clocks stores `b_in` in both registers.
- R12: Rising edges on both clocks in the same instant each capture the pre-edge bus values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset; holds both buses undriven |
| clk_ab | input | 1 | Rising edge captures the A bus into the A-side register |
| clk_ba | input | 1 | Rising edge captures the B bus into the B-side register |
| en_ab | input | 1 | Active-high enable for driving B |
| en_ba_n | input | 1 | Active-low enable for driving A |
| sel_ab | input | 1 | B source: 0 live A, 1 stored A |
| sel_ba | input | 1 | A source: 0 live B, 1 stored B |
| a_in | input | W | Value applied to bus A from outside |
| a_out | output | W | Value the block drives onto bus A |
| a_oe | output | W | Per-bit drive enable for bus A |
| b_in | input | W | Value applied to bus B from outside |
| b_out | output | W | Value the block drives onto bus B |
| b_oe | output | W | Per-bit drive enable for bus B |

## Verification
Enables, selects and bus inputs reach the outputs combinationally, so their effect is due in the same cycle in which they change. A register-backed output is due immediately after the capture-clock rising edge that loads it. The bench changes inputs on the falling edge of its own clock and raises the capture clocks half a nanosecond after the rising edge. It then queues the expected outputs, and the monitor compares them one nanosecond after that rising edge, once both the combinational and captured effects have settled and before the next input change.

// File: rtl/dualbus_xcvr.sv
`timescale 1ns/1ps
module dualbus_xcvr #(
  parameter int W = 8
) (
  input  logic         rst_n,
  input  logic         clk_ab,
  input  logic         clk_ba,
  input  logic         en_ab,
  input  logic         en_ba_n,
  input  logic         sel_ab,
  input  logic         sel_ba,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic [W-1:0] a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic [W-1:0] b_oe
);

  logic         drv_a, drv_b, loop;
  logic [W-1:0] ra, rb, keep, a_nl, b_nl, a_bus, b_bus;

  assign drv_b = rst_n & en_ab;
  assign drv_a = rst_n & ~en_ba_n;
  assign loop  = drv_a & drv_b & ~sel_ab & ~sel_ba;

  assign a_nl = !drv_a ? a_in : sel_ba ? rb : (drv_b && sel_ab) ? ra : b_in;
  assign b_nl = !drv_b ? b_in : sel_ab ? ra : (drv_a && sel_ba) ? rb : a_in;

  always_latch
    if (!rst_n)    keep <= '0;
    else if (!loop) keep <= a_nl;

  assign a_bus = loop ? keep : a_nl;
  assign b_bus = loop ? keep : b_nl;

  always_ff @(posedge clk_ab or negedge rst_n)
    if (!rst_n) ra <= '0;
    else        ra <= a_bus;

  always_ff @(posedge clk_ba or negedge rst_n)
    if (!rst_n) rb <= '0;
    else        rb <= b_bus;

  assign a_out = a_bus;
  assign b_out = b_bus;
  assign a_oe  = {W{drv_a}};
  assign b_oe  = {W{drv_b}};

  logic ab_armed, ba_armed;
  always_ff @(posedge clk_ab or negedge rst_n)
    if (!rst_n) ab_armed <= 1'b0;
    else        ab_armed <= 1'b1;
  always_ff @(posedge clk_ba or negedge rst_n)
    if (!rst_n) ba_armed <= 1'b0;
    else        ba_armed <= 1'b1;

  // R1
  always_comb
    if (!rst_n) reset_quiet_chk: assert (a_oe == '0 && b_oe == '0);

  // R8
  isolate_chk: assert property (@(posedge clk_ab) disable iff (!rst_n)
    (!en_ab && en_ba_n) |-> (a_oe == '0 && b_oe == '0));

  // R4
  live_ab_chk: assert property (@(posedge clk_ab) disable iff (!rst_n)
    (en_ab && !sel_ab && en_ba_n) |-> (b_out == a_in));

  // R5
  stored_ab_chk: assert property (@(posedge clk_ab) disable iff (!rst_n)
    (ab_armed && en_ab && sel_ab) |-> (b_out == $past(a_bus)));

  // R7
  stored_ba_chk: assert property (@(posedge clk_ba) disable iff (!rst_n)
    (ba_armed && !en_ba_n && sel_ba) |-> (a_out == $past(b_bus)));

  // R10
  loop_hold_chk: assert property (@(posedge clk_ab) disable iff (!rst_n)
    (loop && $past(loop)) |-> ($stable(a_out) && b_out == a_out));

endmodule

// File: tb/test_dualbus_xcvr.sv
`timescale 1ns/1ps
module test_dualbus_xcvr;
  localparam int W = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, clk_ab = 1'b0, clk_ba = 1'b0;
  logic en_ab = 1'b0, en_ba_n = 1'b1, sel_ab = 1'b0, sel_ba = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, a_oe, b_out, b_oe;

  dualbus_xcvr #(.W(W)) i_dualbus_xcvr (
    .rst_n(rst_n), .clk_ab(clk_ab), .clk_ba(clk_ba), .en_ab(en_ab),
    .en_ba_n(en_ba_n), .sel_ab(sel_ab), .sel_ba(sel_ba),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe));

  typedef struct {
    string        req;
    logic [W-1:0] ao, bo;
    logic         aoe, boe;
  } exp_t;
  exp_t q[$];

  int checks = 0, failures = 0;
  bit done = 1'b0;
  logic [W-1:0] ra_m = '0, rb_m = '0, keep_m = '0;

  function automatic void model(output logic [W-1:0] av, output logic [W-1:0] bv,
                                output logic lp, output logic [W-1:0] anl);
    logic da, db;
    da = rst_n & ~en_ba_n;
    db = rst_n & en_ab;
    lp = da & db & ~sel_ab & ~sel_ba;
    if (!da)        anl = a_in;
    else if (sel_ba) anl = rb_m;
    else if (!db)   anl = b_in;
    else            anl = ra_m;
    if (!db)          bv = b_in;
    else if (sel_ab)  bv = ra_m;
    else if (!da)     bv = a_in;
    else if (sel_ba)  bv = rb_m;
    else              bv = keep_m;
    av = lp ? keep_m : anl;
  endfunction

  task automatic step(input string tag, input logic r, input logic eab, input logic ebn,
                      input logic sab, input logic sba, input logic [W-1:0] ai,
                      input logic [W-1:0] bi, input logic pab, input logic pba);
    logic [W-1:0] av, bv, anl;
    logic lp;
    exp_t e;
    @(negedge clk);
    clk_ab = 1'b0; clk_ba = 1'b0;
    rst_n = r; en_ab = eab; en_ba_n = ebn; sel_ab = sab; sel_ba = sba;
    a_in = ai; b_in = bi;
    if (!r) begin ra_m = '0; rb_m = '0; keep_m = '0; end
    model(av, bv, lp, anl);
    if (!lp) keep_m = anl;
    @(posedge clk);
    #0.5;
    if (r && pab) ra_m = av;
    if (r && pba) rb_m = bv;
    clk_ab = pab; clk_ba = pba;
    model(av, bv, lp, anl);
    if (!lp) keep_m = anl;
    e.req = tag; e.ao = av; e.bo = bv;
    e.aoe = r & ~ebn; e.boe = r & eab;
    q.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        checks++;
        if (a_oe !== {W{e.aoe}} || b_oe !== {W{e.boe}}) begin
          failures++;
          $display("FAIL %s: a_oe=%h b_oe=%h expected %h %h", e.req, a_oe, b_oe,
                   {W{e.aoe}}, {W{e.boe}});
        end
        if (e.aoe) begin
          checks++;
          if (a_out !== e.ao) begin
            failures++;
            $display("FAIL %s: a_out=%h expected %h", e.req, a_out, e.ao);
          end
        end
        if (e.boe) begin
          checks++;
          if (b_out !== e.bo) begin
            failures++;
            $display("FAIL %s: b_out=%h expected %h", e.req, b_out, e.bo);
          end
        end
      end
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : driver
    //   tag                 rst eab ebn sab sba a_in   b_in   pab  pba
    step("R1 reset",          0,  1,  0,  1,  1, 8'h12, 8'h34, 1,   1);
    step("R8 isolation",      1,  0,  1,  0,  0, 8'h12, 8'h34, 0,   0);
    step("R1 cleared reg",    1,  1,  1,  1,  0, 8'h12, 8'h34, 0,   0);
    step("R2 R4 live A->B",   1,  1,  1,  0,  0, 8'h3C, 8'h34, 0,   0);
    step("R4 live change",    1,  1,  1,  0,  0, 8'hA5, 8'h34, 0,   0);
    step("R12 R8 capture",    1,  0,  1,  1,  1, 8'h5A, 8'hC3, 1,   1);
    step("R9 swap",           1,  1,  0,  1,  1, 8'h00, 8'hFF, 0,   0);
    step("R6 idle inputs",    1,  1,  0,  1,  1, 8'h99, 8'h66, 0,   0);
    step("R3 R4 live B->A",   1,  0,  0,  1,  0, 8'h99, 8'h4E, 0,   0);
    step("R3 active low",     1,  0,  1,  1,  0, 8'h99, 8'h4E, 0,   0);
    step("R7 capture B",      1,  0,  1,  0,  0, 8'h01, 8'hB7, 0,   1);
    step("R5 R7 stored B->A", 1,  0,  0,  0,  1, 8'h02, 8'h00, 0,   0);
    step("R11 capture driven",1,  1,  0,  0,  1, 8'h03, 8'h04, 1,   0);
    step("R6 R11 stored A",   1,  1,  0,  1,  1, 8'h05, 8'h06, 0,   0);
    step("R11 store B both",  1,  0,  0,  0,  0, 8'h07, 8'hD2, 1,   1);
    step("R11 R9 check both", 1,  1,  0,  1,  1, 8'h08, 8'h09, 0,   0);
    step("R4 pre loop",       1,  1,  1,  0,  0, 8'h77, 8'h10, 0,   0);
    step("R10 enter loop",    1,  1,  0,  0,  0, 8'h77, 8'h10, 0,   0);
    step("R10 inputs ignored",1,  1,  0,  0,  0, 8'h11, 8'h22, 0,   0);
    step("R10 R6 loop capture",1, 1,  0,  0,  0, 8'h33, 8'h44, 1,   1);
    step("R6 falling edge",   1,  1,  0,  1,  1, 8'h55, 8'h66, 0,   0);
    step("R6 R9 loop stored", 1,  1,  0,  1,  1, 8'h55, 8'h66, 0,   0);
    step("R1 reset again",    0,  1,  0,  0,  0, 8'hEE, 8'hDD, 0,   0);
    step("R1 R9 regs cleared",1,  1,  0,  1,  1, 8'hEE, 8'hDD, 0,   0);
    repeat (3) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule